// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte Forwarding

This block is a single-port synchronous memory with a pipelined read and a late-write protocol. A command (select, write enable, address and per-lane write enables) is sampled on one rising clock edge. For a write, the data follows on the next edge. The write is not placed in the array at once. Its address, lane enables and data are held in a one-entry write buffer, and the array is updated only when the next write command is accepted. Any number of reads may come in between.

Each read compares its address with the buffered write. On a match, the lanes enabled in the pending write come from the buffer, and the remaining lanes come from the array. The read latency is the same either way. Read data leaves through a registered output. That output holds its value between reads, so a device clocked more slowly can sample the same word over several cycles.

A sleep input freezes the block. It ignores every command, stops driving the output, and keeps the array and buffer contents. The output is modelled as a data vector plus a drive-enable. A de-asserted drive-enable stands for high impedance, and the data vector then reads zero.

Top module: `lw_sram`

## Requirements
- R1: A read command (sel_n=0, wr_n=1, sleep=0) sampled at edge N loads the output register at edge N+1. From then on dout shows that word and dout_en is high while oe_n is low. Between edge N and edge N+1, dout_en stays low if no read preceded.
- R2: A write command (sel_n=0, wr_n=0, sleep=0) samples addr and be_n at edge N. The matching wdata is sampled at edge N+1.
- R3: A buffered write enters the array only when the next write command is accepted. When that next command follows immediately, the data sampled on that same edge is the data committed. Reset discards a pending write that was never committed.
- R4: Lane i occupies dout/wdata bits [9i+8:9i]. be_n[i]=0 enables lane i. On commit, lanes with be_n[i]=1 keep their previous array contents.
- R5: A read whose address equals the buffered write address returns the enabled lanes from the buffer and the other lanes from the array, with the R1 latency.
- R6: The output register changes only on an accepted read. Back-to-back reads of the same address keep dout constant. A cycle with no accepted read drops dout_en at the next edge.
- R7: With sel_n=1 the cycle is a deselect. wr_n, addr, be_n and wdata have no effect on the array, the buffer or the output register.
- R8: While sleep=1, dout_en is low and dout is zero without waiting for a clock edge. All commands and write data are ignored, and the array and buffer keep their contents.
- R9: oe_n=1 forces dout_en low and dout to zero within the same cycle, without altering the pipeline. When oe_n returns low, the held word reappears.
- R10: Reset leaves dout_en low and dout zero, and marks the write buffer empty. No read forwards from the buffer until a new write is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request; freezes the block |
| sel_n | input | 1 | Active-low command select |
| wr_n | input | 1 | Active-low global write enable |
| be_n | input | NBYTES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTE_W*NBYTES | Write data, one cycle after its command |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dout | output | BYTE_W*NBYTES | Read data, zero when not driven |
| dout_en | output | 1 | High when dout is driven |

## Verification
The bench builds the block with ADDR_W=4, BYTE_W=9 and NBYTES=4. This gives a sixteen-word array in which every address the scenarios touch is chosen by hand, and nine-bit lanes that test slicing on boundaries that are not powers of two. With this small depth, the bench can place back-to-back writes, partial-lane overwrites of a pending word, and a reset that discards an uncommitted write at known addresses. It then checks the forwarded or array value for each at its exact cycle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   // Command decoded from select / write enable / sleep at a sampling edge
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } lw_op_e;

   // Decode one sampling edge's command inputs
   function automatic lw_op_e decode_op(input logic sleep, input logic sel_n, input logic wr_n);
      if (sleep || sel_n) return OP_IDLE;
      return wr_n ? OP_READ : OP_WRITE;
   endfunction

endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic [NBYTES-1:0] be_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_go_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [NBYTES-1:0] wr_be_o,
   output logic              rd_vld_o,
   output logic [ADDR_W-1:0] rd_addr_o
);

   lw_op_e op;
   logic   rd_vld_q;
   logic [ADDR_W-1:0] rd_addr_q;

   assign op        = decode_op(sleep, sel_n, wr_n);
   assign wr_go_o   = (op == OP_WRITE);
   assign wr_addr_o = addr;
   assign wr_be_o   = ~be_n;

   // First read stage: address captured on the command edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld_q  <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         rd_vld_q <= (op == OP_READ);
         if (op == OP_READ) rd_addr_q <= addr;
      end
   end

   assign rd_vld_o  = rd_vld_q;
   assign rd_addr_o = rd_addr_q;

endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep,
   input  logic                     wr_go_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [NBYTES-1:0]        wr_be_i,
   input  logic [BYTE_W*NBYTES-1:0] wdata_i,
   // pending entry, seen by the read comparator
   output logic                     wb_vld_o,
   output logic [ADDR_W-1:0]        wb_addr_o,
   output logic [NBYTES-1:0]        wb_be_o,
   output logic [BYTE_W*NBYTES-1:0] wb_data_o,
   // commit port toward the array
   output logic                     cm_en_o,
   output logic [ADDR_W-1:0]        cm_addr_o,
   output logic [NBYTES-1:0]        cm_be_o,
   output logic [BYTE_W*NBYTES-1:0] cm_data_o
);

   localparam int DATA_W = BYTE_W * NBYTES;

   logic              vld_q, due_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NBYTES-1:0] be_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         due_q  <= 1'b0;
         addr_q <= '0;
         be_q   <= '0;
         data_q <= '0;
      end else begin
         due_q <= wr_go_i;
         if (due_q && !sleep) data_q <= wdata_i;
         if (wr_go_i) begin
            vld_q  <= 1'b1;
            addr_q <= wr_addr_i;
            be_q   <= wr_be_i;
         end
      end
   end

   // A new write pushes the previous entry into the array; if that entry's
   // data is arriving on this very edge, it is taken straight from the input.
   assign cm_en_o   = wr_go_i && vld_q;
   assign cm_addr_o = addr_q;
   assign cm_be_o   = be_q;
   assign cm_data_o = due_q ? wdata_i : data_q;

   assign wb_vld_o  = vld_q;
   assign wb_addr_o = addr_q;
   assign wb_be_o   = be_q;
   assign wb_data_o = data_q;

   // R2
   data_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      due_q |-> vld_q);

   // R3
   buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go_i |=> $stable(addr_q) && $stable(be_q));

   // R8
   sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(addr_q) && $stable(be_q) && $stable(data_q) && $stable(vld_q));

endmodule

// File: rtl/lw_mem_array.sv
module lw_mem_array #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        we_addr_i,
   input  logic [NBYTES-1:0]        we_be_i,
   input  logic [BYTE_W*NBYTES-1:0] we_data_i,
   input  logic [ADDR_W-1:0]        rd_addr_i,
   output logic [BYTE_W*NBYTES-1:0] rd_data_o
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("lw_mem_array: ADDR_W out of range 1..12");
   end
   if (BYTE_W < 1 || NBYTES < 1) begin : g_bad_lane
      $error("lw_mem_array: lane width and count must be positive");
   end

   // One independent storage column per lane
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we_i && we_be_i[i]) cells[we_addr_i] <= we_data_i[i*BYTE_W +: BYTE_W];
      end

      assign rd_data_o[i*BYTE_W +: BYTE_W] = cells[rd_addr_i];
   end

   // R4
   lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> !$isunknown(we_be_i));

endmodule

// File: rtl/lw_read_out.sv
module lw_read_out #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep,
   input  logic                     oe_n,
   input  logic                     rd_vld_i,
   input  logic [ADDR_W-1:0]        rd_addr_i,
   input  logic [BYTE_W*NBYTES-1:0] arr_data_i,
   input  logic                     wb_vld_i,
   input  logic [ADDR_W-1:0]        wb_addr_i,
   input  logic [NBYTES-1:0]        wb_be_i,
   input  logic [BYTE_W*NBYTES-1:0] wb_data_i,
   output logic [BYTE_W*NBYTES-1:0] dout_o,
   output logic                     dout_en_o
);

   localparam int DATA_W = BYTE_W * NBYTES;

   logic              hit;
   logic              take;
   logic [DATA_W-1:0] merged;
   logic              vld_q;
   logic [DATA_W-1:0] dout_q;

   assign hit  = wb_vld_i && (wb_addr_i == rd_addr_i);
   assign take = rd_vld_i && !sleep;

   // Per-lane choice between pending write data and array data
   for (genvar i = 0; i < NBYTES; i++) begin : g_fwd
      assign merged[i*BYTE_W +: BYTE_W] = (hit && wb_be_i[i]) ? wb_data_i[i*BYTE_W +: BYTE_W]
                                                              : arr_data_i[i*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         dout_q <= '0;
      end else begin
         vld_q <= take;
         if (take) dout_q <= merged;
      end
   end

   assign dout_en_o = vld_q && !oe_n && !sleep;
   assign dout_o    = dout_en_o ? dout_q : '0;

   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld_i |=> $stable(dout_q));

   // R9
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (dout_o == '0));

endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep,
   input  logic                     sel_n,
   input  logic                     wr_n,
   input  logic [NBYTES-1:0]        be_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [BYTE_W*NBYTES-1:0] wdata,
   input  logic                     oe_n,
   output logic [BYTE_W*NBYTES-1:0] dout,
   output logic                     dout_en
);

   localparam int DATA_W = BYTE_W * NBYTES;

   if (DATA_W > 1024) begin : g_bad_width
      $error("lw_sram: word wider than 1024 bits");
   end

   logic              wr_go, rd_vld, wb_vld, cm_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr, wb_addr, cm_addr;
   logic [NBYTES-1:0] wr_be, wb_be, cm_be;
   logic [DATA_W-1:0] wb_data, cm_data, arr_data;

   lw_cmd_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_dec (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
      .be_n(be_n), .addr(addr),
      .wr_go_o(wr_go), .wr_addr_o(wr_addr), .wr_be_o(wr_be),
      .rd_vld_o(rd_vld), .rd_addr_o(rd_addr)
   );

   lw_write_buffer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .sleep(sleep),
      .wr_go_i(wr_go), .wr_addr_i(wr_addr), .wr_be_i(wr_be), .wdata_i(wdata),
      .wb_vld_o(wb_vld), .wb_addr_o(wb_addr), .wb_be_o(wb_be), .wb_data_o(wb_data),
      .cm_en_o(cm_en), .cm_addr_o(cm_addr), .cm_be_o(cm_be), .cm_data_o(cm_data)
   );

   lw_mem_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .we_i(cm_en), .we_addr_i(cm_addr), .we_be_i(cm_be), .we_data_i(cm_data),
      .rd_addr_i(rd_addr), .rd_data_o(arr_data)
   );

   lw_read_out #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_rout (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
      .rd_vld_i(rd_vld), .rd_addr_i(rd_addr), .arr_data_i(arr_data),
      .wb_vld_i(wb_vld), .wb_addr_i(wb_addr), .wb_be_i(wb_be), .wb_data_i(wb_data),
      .dout_o(dout), .dout_en_o(dout_en)
   );

   // R1
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && wr_n && !sleep) ##1 !sleep |=> (oe_n || sleep || dout_en));

   // R10
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_en && !$past(rst_n)) |-> 1'b0);

endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;

   localparam int AW = 4;
   localparam int BW = 9;
   localparam int NB = 4;
   localparam int DW = BW * NB;

   localparam logic [DW-1:0] VA = 36'h123456789;
   localparam logic [DW-1:0] VB = 36'hFEDCBA987;
   localparam logic [DW-1:0] VC = 36'h0F0F0F0F0;
   localparam logic [DW-1:0] V0 = 36'hABCDEF012;
   localparam logic [DW-1:0] V1 = 36'h111111111;
   localparam logic [DW-1:0] V2 = 36'h222222222;
   localparam logic [DW-1:0] VP = 36'h5A5A5A5A5;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, sleep, sel_n, wr_n, oe_n, dout_en;
   logic [NB-1:0] be_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, dout;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   lw_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB)) uut (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
      .be_n(be_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Lanes with be_n bit low take the new value
   function automatic logic [DW-1:0] mix(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                         input logic [NB-1:0] bn);
      logic [DW-1:0] r;
      for (int i = 0; i < NB; i++)
         r[i*BW +: BW] = bn[i] ? old_w[i*BW +: BW] : new_w[i*BW +: BW];
      return r;
   endfunction

   // Drive one cycle of inputs, then pass one rising edge (returns at negedge)
   task automatic cyc(input logic s_n, input logic w_n, input logic [AW-1:0] a,
                      input logic [NB-1:0] b_n, input logic [DW-1:0] d);
      sel_n = s_n; wr_n = w_n; addr = a; be_n = b_n; wdata = d;
      @(negedge clk);
   endtask

   task automatic idle(input logic [DW-1:0] d);
      cyc(1'b1, 1'b1, '0, '1, d);
   endtask

   task automatic rd(input logic [AW-1:0] a);
      cyc(1'b0, 1'b1, a, '1, '0);
   endtask

   task automatic wrc(input logic [AW-1:0] a, input logic [NB-1:0] b_n, input logic [DW-1:0] d_prev);
      cyc(1'b0, 1'b0, a, b_n, d_prev);
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      rd(a);
      idle('0);
      chk(req, dout, exp);
      chk(req, {{(DW-1){1'b0}}, dout_en}, 1);
   endtask

   task automatic t_reset_state;
      chk("R10 dout_en in reset", {{(DW-1){1'b0}}, dout_en}, 0);
      chk("R10 dout in reset", dout, '0);
   endtask

   task automatic t_basic;
      wrc(4'd1, 4'b0000, '0);
      wrc(4'd2, 4'b0000, VA);
      idle(VB);
      rd(4'd1);
      chk("R1 no output before second edge", {{(DW-1){1'b0}}, dout_en}, 0);
      idle('0);
      chk("R1 read data after one cycle", dout, VA);
      chk("R1 drive enable", {{(DW-1){1'b0}}, dout_en}, 1);
      rd_chk("R5 full-lane forward", 4'd2, VB);
      rd_chk("R2 data taken one edge late", 4'd1, VA);
   endtask

   task automatic t_bytes;
      wrc(4'd3, 4'b0000, '0);
      wrc(4'd3, 4'b1010, V0);
      idle(V1);
      rd_chk("R5 per-lane forward", 4'd3, mix(V0, V1, 4'b1010));
      wrc(4'd4, 4'b0000, '0);
      idle(VC);
      rd_chk("R4 partial commit keeps lanes", 4'd3, mix(V0, V1, 4'b1010));
      rd_chk("R5 forward new entry", 4'd4, VC);
   endtask

   task automatic t_commit;
      wrc(4'd5, 4'b0000, '0);
      wrc(4'd6, 4'b0000, V2);
      wrc(4'd7, 4'b0000, V1);
      idle(VP);
      rd_chk("R3 back-to-back commit first", 4'd5, V2);
      rd_chk("R3 back-to-back commit second", 4'd6, V1);
      wrc(4'd8, 4'b0000, '0);
      idle(VB);
      rd(4'd1); rd(4'd1); rd(4'd2);
      idle('0);
      rd_chk("R3 pending survives reads", 4'd8, VB);
      rd_chk("R3 previous now in array", 4'd7, VP);
   endtask

   task automatic t_b2b;
      rd(4'd1);
      rd(4'd1);
      chk("R6 same address first", dout, VA);
      rd(4'd1);
      chk("R6 same address second", dout, VA);
      idle('0);
      chk("R6 same address third", dout, VA);
      idle('0);
      chk("R6 drive drops without read", {{(DW-1){1'b0}}, dout_en}, 0);
      rd(4'd1);
      rd(4'd2);
      chk("R1 pipelined first", dout, VA);
      idle('0);
      chk("R1 pipelined second", dout, VB);
   endtask

   task automatic t_deselect;
      cyc(1'b1, 1'b0, 4'd1, 4'b0000, '0);
      idle(VC);
      rd_chk("R7 deselect leaves array", 4'd1, VA);
      rd_chk("R7 deselect leaves buffer", 4'd8, VB);
   endtask

   task automatic t_oe;
      oe_n = 1'b1;
      rd(4'd1);
      idle('0);
      chk("R9 oe_n high no drive", {{(DW-1){1'b0}}, dout_en}, 0);
      chk("R9 oe_n high zero data", dout, '0);
      oe_n = 1'b0;
      #1;
      chk("R9 oe_n low restores word", dout, VA);
   endtask

   task automatic t_sleep;
      rd(4'd1);
      idle('0);
      chk("R8 pre-sleep word", dout, VA);
      sleep = 1'b1;
      #1;
      chk("R8 sleep stops drive", {{(DW-1){1'b0}}, dout_en}, 0);
      chk("R8 sleep zero data", dout, '0);
      @(negedge clk);
      wrc(4'd1, 4'b0000, '0);
      idle(VC);
      rd(4'd8);
      idle('0);
      chk("R8 read ignored in sleep", {{(DW-1){1'b0}}, dout_en}, 0);
      sleep = 1'b0;
      rd_chk("R8 array kept", 4'd1, VA);
      rd_chk("R8 buffer kept", 4'd8, VB);
   endtask

   task automatic t_reset_pending;
      wrc(4'd9, 4'b0000, '0);
      wrc(4'd10, 4'b0000, V1);
      wrc(4'd9, 4'b0000, VC);
      idle(V2);
      rd_chk("R5 pending before reset", 4'd9, V2);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 output off after reset", {{(DW-1){1'b0}}, dout_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R10 no forward after reset", 4'd9, V1);
      rd_chk("R3 committed word kept", 4'd10, VC);
   endtask

   initial begin
      rst_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
      sel_n = 1'b1; wr_n = 1'b1; be_n = '1; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_bytes();
      t_commit();
      t_b2b();
      t_deselect();
      t_oe();
      t_sleep();
      t_reset_pending();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule